// File: doc/BRIEF.md
# Circular Receive Message Buffer Controller

This block manages a 64-byte ring of storage that holds received CAN messages of different lengths, one after another. The receive side writes the bytes of a finished message at offsets from the current write position, then pulses a store event. The block keeps a start pointer to the first byte of the oldest unread message, a write position behind the newest message, and a count of complete messages waiting.

A CPU-side byte port reads a 13-byte window that begins at the start pointer, the message count, the start pointer and a direct view of the whole ring. The CPU moves to the next message with a release pulse. The step size comes from the frame-info byte, which is the first byte of each message. Any byte position past 63 wraps to 0.

A hardware reset clears the pointer. A software reset is a level on the reset-mode input. It keeps the pointer and the ring contents and clears the message count, so the next stored message lands on top of the one that was visible. While reset mode is active, the CPU may write the pointer and the ring.

Top module: `rx_ring_ctrl`

## Requirements
- R1: Hardware reset (rst_ni low) sets the start pointer to 0 and the message count to 0.
- R2: A store pulse in operating mode adds one to the count. Reading CPU offset 13 returns the count in bits 4:0, with bits 7:5 zero. Writes to offset 13 have no effect.
- R3: A release pulse in operating mode with a nonzero count subtracts one from the count. It also advances the pointer, modulo 64, by the length of the message at the pointer. That length is 3 plus the capped DLC when bit 7 of the frame-info byte is 0, and 5 plus the capped DLC when bit 7 is 1. The capped DLC is bits 3:0 of the frame-info byte, limited to 8.
- R4: A release pulse while the count is zero changes neither the pointer nor the count.
- R5: A store pulse and a release pulse in the same cycle with a nonzero count leave the count unchanged and still advance the pointer.
- R6: A receive byte write at offset k goes to ring address (write position + k) mod 64. Each store advances the write position by the length of the message stored there. CPU offset k, for k from 0 to 12, reads ring[(pointer + k) mod 64].
- R7: While reset mode is high, the count is held at 0. The pointer and the ring contents are kept, and store, release and receive writes are ignored. The first message stored after reset mode ends starts at the pointer.
- R8: CPU offset 14 reads the pointer in bits 5:0, with bits 7:6 zero. A write to offset 14 changes the pointer only in reset mode, and the new value is visible after the next clock edge.
- R9: CPU offset 32 + a, for a from 0 to 63, reads ring byte a. A write to these offsets changes the ring only in reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| reset_mode_i | input | 1 | Software reset / reset mode level |
| rx_wr_i | input | 1 | Receive byte write strobe |
| rx_off_i | input | 4 | Byte offset from write position |
| rx_data_i | input | 8 | Receive byte |
| rx_store_i | input | 1 | Message complete pulse |
| rel_i | input | 1 | Release current message pulse |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 7 | CPU byte offset |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational) |

## Verification
The assertions take several things for granted about the inputs. A store is never issued with the count already at 31. A store is never issued in the same cycle as a receive write to offset 0. Receive writes arrive only in operating mode, and the CPU offset holds still across each clock edge. The stimulus keeps to these limits: it never holds more than eight messages, it writes every message byte before the store pulse, and it changes inputs only at the falling clock edge. The bench model tracks the ring, the pointer, the write position and the count with plain integers, and it checks the CPU read value every cycle.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef logic [7:0] byte_t;

  localparam int HDR_STD = 3;
  localparam int HDR_EXT = 5;
  localparam int DLC_MAX = 8;

  // message length from frame-info byte: bit 7 selects long header, bits 3:0 = DLC
  function automatic logic [3:0] msg_len(input byte_t info);
    logic [3:0] dlc;
    dlc = info[3:0];
    if (dlc > 4'(DLC_MAX)) dlc = 4'(DLC_MAX);
    return (info[7] ? 4'(HDR_EXT) : 4'(HDR_STD)) + dlc;
  endfunction
endpackage

// File: rtl/rx_ring_ram.sv
module rx_ring_ram
  import rx_ring_pkg::*;
#(
  parameter int AW  = 6,
  parameter int NRD = 3
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  byte_t                   wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output byte_t [NRD-1:0]         rdata_o
);
  localparam int DEPTH = 1 << AW;

  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/rx_ring_ptrs.sv
module rx_ring_ptrs
  import rx_ring_pkg::*;
#(
  parameter int AW = 6,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_rst_i,
  input  logic          store_i,
  input  logic          rel_i,
  input  logic          ptr_we_i,
  input  logic [AW-1:0] ptr_wdata_i,
  input  byte_t         rd_info_i,
  input  byte_t         wr_info_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] ptr_q, ptr_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_ok, st_ok;

  always_comb begin
    rel_ok = !mode_rst_i && rel_i && (cnt_q != '0);
    st_ok  = !mode_rst_i && store_i;

    ptr_d = ptr_q;
    if (rel_ok) ptr_d = ptr_q + AW'(msg_len(rd_info_i));
    if (mode_rst_i && ptr_we_i) ptr_d = ptr_wdata_i;

    // queue flushed in reset mode: write position follows the pointer
    if (mode_rst_i)  wr_d = ptr_d;
    else if (st_ok)  wr_d = wr_q + AW'(msg_len(wr_info_i));
    else             wr_d = wr_q;

    cnt_d = cnt_q;
    if (mode_rst_i)             cnt_d = '0;
    else if (st_ok && !rel_ok)  cnt_d = cnt_q + CW'(1);
    else if (!st_ok && rel_ok)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign wr_ptr_o = wr_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/rx_ring_rdmux.sv
module rx_ring_rdmux
  import rx_ring_pkg::*;
#(
  parameter int AW       = 6,
  parameter int CW       = 5,
  parameter int CA_W     = 7,
  parameter int WIN_LEN  = 13,
  parameter int CNT_OFS  = 13,
  parameter int PTR_OFS  = 14,
  parameter int RAM_BASE = 32
) (
  input  logic [CA_W-1:0] cpu_addr_i,
  input  logic [AW-1:0]   ptr_i,
  input  logic [CW-1:0]   cnt_i,
  input  byte_t           ram_rdata_i,
  output logic [AW-1:0]   ram_addr_o,
  output logic            in_ram_o,
  output byte_t           rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic in_win;

  always_comb begin
    in_win   = cpu_addr_i < CA_W'(WIN_LEN);
    in_ram_o = (cpu_addr_i >= CA_W'(RAM_BASE)) && (cpu_addr_i < CA_W'(RAM_BASE + DEPTH));

    ram_addr_o = ptr_i + AW'(cpu_addr_i);
    if (in_ram_o) ram_addr_o = AW'(cpu_addr_i - CA_W'(RAM_BASE));

    if (in_win || in_ram_o)                rdata_o = ram_rdata_i;
    else if (cpu_addr_i == CA_W'(CNT_OFS)) rdata_o = byte_t'(cnt_i);
    else if (cpu_addr_i == CA_W'(PTR_OFS)) rdata_o = byte_t'(ptr_i);
    else                                   rdata_o = '0;
  end
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int AW       = 6,
  parameter int CW       = 5,
  parameter int OFF_W    = 4,
  parameter int CA_W     = 7,
  parameter int WIN_LEN  = 13,
  parameter int CNT_OFS  = 13,
  parameter int PTR_OFS  = 14,
  parameter int RAM_BASE = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reset_mode_i,
  input  logic            rx_wr_i,
  input  logic [OFF_W-1:0] rx_off_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_store_i,
  input  logic            rel_i,
  input  logic            cpu_we_i,
  input  logic [CA_W-1:0] cpu_addr_i,
  input  logic [7:0]      cpu_wdata_i,
  output logic [7:0]      cpu_rdata_o
);
  localparam int NRD = 3;

  logic [AW-1:0]          ptr_w, wr_ptr_w, cpu_ram_addr;
  logic [CW-1:0]          cnt_w;
  logic                   cpu_in_ram;
  logic [NRD-1:0][AW-1:0] rd_addr;
  byte_t [NRD-1:0]        rd_data;
  logic                   ram_we;
  logic [AW-1:0]          ram_waddr;
  byte_t                  ram_wdata;
  logic                   ptr_we;

  assign rd_addr = {wr_ptr_w, ptr_w, cpu_ram_addr};

  // ring is written by the CPU in reset mode, by the receiver otherwise
  always_comb begin
    if (reset_mode_i) begin
      ram_we    = cpu_we_i && cpu_in_ram;
      ram_waddr = cpu_ram_addr;
      ram_wdata = cpu_wdata_i;
    end else begin
      ram_we    = rx_wr_i;
      ram_waddr = wr_ptr_w + AW'(rx_off_i);
      ram_wdata = rx_data_i;
    end
  end

  assign ptr_we = cpu_we_i && (cpu_addr_i == CA_W'(PTR_OFS));

  rx_ring_ram #(.AW(AW), .NRD(NRD)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  rx_ring_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_rst_i  (reset_mode_i),
    .store_i     (rx_store_i),
    .rel_i       (rel_i),
    .ptr_we_i    (ptr_we),
    .ptr_wdata_i (cpu_wdata_i[AW-1:0]),
    .rd_info_i   (rd_data[1]),
    .wr_info_i   (rd_data[2]),
    .ptr_o       (ptr_w),
    .wr_ptr_o    (wr_ptr_w),
    .cnt_o       (cnt_w)
  );

  rx_ring_rdmux #(
    .AW(AW), .CW(CW), .CA_W(CA_W), .WIN_LEN(WIN_LEN),
    .CNT_OFS(CNT_OFS), .PTR_OFS(PTR_OFS), .RAM_BASE(RAM_BASE)
  ) u_rdmux (
    .cpu_addr_i  (cpu_addr_i),
    .ptr_i       (ptr_w),
    .cnt_i       (cnt_w),
    .ram_rdata_i (rd_data[0]),
    .ram_addr_o  (cpu_ram_addr),
    .in_ram_o    (cpu_in_ram),
    .rdata_o     (cpu_rdata_o)
  );
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int AW      = 6,
  parameter int CW      = 5,
  parameter int CA_W    = 7,
  parameter int CNT_OFS = 13,
  parameter int PTR_OFS = 14
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_i,
  input logic            store_i,
  input logic            rel_i,
  input logic            cpu_we_i,
  input logic [CA_W-1:0] cpu_addr_i,
  input logic [7:0]      cpu_wdata_i,
  input logic [7:0]      cpu_rdata_i,
  input logic [AW-1:0]   ptr_i,
  input logic [CW-1:0]   cnt_i
);
  p_hw_rst_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (ptr_i == '0) && (cnt_i == '0));

  p_cnt_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && store_i && !rel_i) |=> cnt_i == $past(cnt_i) + CW'(1));

  p_cnt_hi_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i == CA_W'(CNT_OFS)) |-> (cpu_rdata_i[7:CW] == '0));

  p_cnt_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && rel_i && !store_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - CW'(1));

  p_rel_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && rel_i && !store_i && cnt_i == '0) |=> (cnt_i == '0) && $stable(ptr_i));

  p_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && rel_i && store_i) |=> $stable(cnt_i));

  p_mode_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> (cnt_i == '0));

  p_ptr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !rel_i) |=> $stable(ptr_i));

  p_ptr_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && cpu_we_i && cpu_addr_i == CA_W'(PTR_OFS)) |=> ptr_i == $past(cpu_wdata_i[AW-1:0]));

  p_ptr_hi_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i == CA_W'(PTR_OFS)) |-> (cpu_rdata_i[7:AW] == '0));
endmodule

bind rx_ring_ctrl rx_ring_chk #(
  .AW(AW), .CW(CW), .CA_W(CA_W), .CNT_OFS(CNT_OFS), .PTR_OFS(PTR_OFS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (reset_mode_i),
  .store_i     (rx_store_i),
  .rel_i       (rel_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_rdata_i (cpu_rdata_o),
  .ptr_i       (ptr_w),
  .cnt_i       (cnt_w)
);

// File: tb/sim_rx_ring_ctrl.sv
`timescale 1ns/1ps
module sim_rx_ring_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       rm = 1'b1;
  logic       rx_wr = 1'b0;
  logic [3:0] rx_off = '0;
  logic [7:0] rx_data = '0;
  logic       store = 1'b0;
  logic       rel = 1'b0;
  logic       cpu_we = 1'b0;
  logic [6:0] cpu_addr = 7'd13;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  rx_ring_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reset_mode_i(rm),
    .rx_wr_i(rx_wr), .rx_off_i(rx_off), .rx_data_i(rx_data), .rx_store_i(store),
    .rel_i(rel), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata)
  );

  // behavioural reference
  int m_mem [64];
  int m_ptr = 0, m_wr = 0, m_cnt = 0;

  function automatic int mlen(int info);
    int d = info % 16;
    if (d > 8) d = 8;
    return ((info / 128) % 2 == 1 ? 5 : 3) + d;
  endfunction

  function automatic int m_rd(int a);
    if (a < 13) return m_mem[(m_ptr + a) % 64];
    if (a == 13) return m_cnt;
    if (a == 14) return m_ptr;
    if (a >= 32 && a < 96) return m_mem[a - 32];
    return 0;
  endfunction

  initial for (int i = 0; i < 64; i++) m_mem[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_wr = 0; m_cnt = 0;
    end else if (rm) begin
      if (cpu_we && cpu_addr >= 32 && cpu_addr < 96) m_mem[cpu_addr - 32] = cpu_wdata;
      if (cpu_we && cpu_addr == 14) m_ptr = cpu_wdata % 64;
      m_cnt = 0;
      m_wr = m_ptr;
    end else begin
      int lr, lw;
      bit ok;
      ok = rel && m_cnt > 0;
      lr = mlen(m_mem[m_ptr]);
      lw = mlen(m_mem[m_wr]);
      if (rx_wr) m_mem[(m_wr + rx_off) % 64] = rx_data;
      if (ok) m_ptr = (m_ptr + lr) % 64;
      if (store) m_wr = (m_wr + lw) % 64;
      m_cnt = m_cnt + int'(store) - int'(ok);
    end
  end

  task automatic step(input string r);
    int e;
    @(negedge clk);
    e = m_rd(cpu_addr);
    n_cmp++;
    if (cpu_rdata !== 8'(e)) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h", r, cpu_addr, cpu_rdata, 8'(e));
    end
  endtask

  task automatic rx_msg(input logic [7:0] info, input bit with_rel, input string r);
    for (int k = 0; k < mlen(info); k++) begin
      rx_wr = 1'b1; rx_off = 4'(k);
      rx_data = (k == 0) ? info : 8'(k * 17 + info);
      step(r);
    end
    rx_wr = 1'b0; store = 1'b1; rel = with_rel;
    step(r);
    store = 1'b0; rel = 1'b0;
    step(r);
  endtask

  task automatic scan_win(input string r);
    for (int k = 0; k < 13; k++) begin
      cpu_addr = 7'(k);
      step(r);
    end
    cpu_addr = 7'd14; step(r);
    cpu_addr = 7'd13; step(r);
  endtask

  task automatic release_one(input string r);
    rel = 1'b1; step(r);
    rel = 1'b0; cpu_addr = 7'd14; step(r);
    cpu_addr = 7'd13; step(r);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    step("R1"); step("R1");
    cpu_addr = 7'd14; step("R1");
    rst_n = 1'b1; step("R1");

    // fill ring through the direct view in reset mode
    for (int i = 0; i < 64; i++) begin
      cpu_addr = 7'(32 + i); cpu_we = 1'b1; cpu_wdata = 8'(i * 37 + 11);
      step("R9");
    end
    cpu_we = 1'b0;
    cpu_addr = 7'd45; step("R9");
    rm = 1'b0; step("R7");

    // operating-mode writes have no effect
    cpu_addr = 7'd40; cpu_we = 1'b1; cpu_wdata = 8'hA5; step("R9");
    cpu_we = 1'b0; step("R9");
    cpu_addr = 7'd14; cpu_we = 1'b1; cpu_wdata = 8'h21; step("R8");
    cpu_we = 1'b0; step("R8");
    cpu_addr = 7'd13; cpu_we = 1'b1; cpu_wdata = 8'h1F; step("R2");
    cpu_we = 1'b0; step("R2");

    // seven messages, last one crosses address 63
    rx_msg(8'h02, 1'b0, "R2");
    rx_msg(8'h88, 1'b0, "R6");
    rx_msg(8'h0F, 1'b0, "R3");
    rx_msg(8'h80, 1'b0, "R6");
    rx_msg(8'h88, 1'b0, "R2");
    rx_msg(8'h08, 1'b0, "R6");
    rx_msg(8'h8C, 1'b0, "R6");
    scan_win("R6");

    // store and release together
    rx_msg(8'h05, 1'b1, "R5");
    scan_win("R5");

    for (int i = 0; i < 7; i++) begin
      release_one("R3");
      scan_win("R6");
    end

    // release on empty queue
    cpu_addr = 7'd14;
    rel = 1'b1; step("R4");
    step("R4");
    rel = 1'b0; cpu_addr = 7'd13; step("R4");
    scan_win("R4");

    // software reset
    rx_msg(8'h83, 1'b0, "R7");
    rx_msg(8'h01, 1'b0, "R7");
    rm = 1'b1; step("R7");
    step("R7");
    cpu_addr = 7'd14; step("R7");
    rel = 1'b1; store = 1'b1; rx_wr = 1'b1; rx_off = 4'd0; rx_data = 8'h77; step("R7");
    rel = 1'b0; store = 1'b0; rx_wr = 1'b0; step("R7");
    scan_win("R7");
    cpu_addr = 7'd14; cpu_we = 1'b1; cpu_wdata = 8'hFC; step("R8");
    cpu_we = 1'b0; step("R8");
    cpu_addr = 7'd100; cpu_we = 1'b1; cpu_wdata = 8'h3C; step("R9");
    cpu_we = 1'b0; step("R9");
    cpu_addr = 7'd33; cpu_we = 1'b1; cpu_wdata = 8'h5A; step("R9");
    cpu_we = 1'b0; step("R9");
    rm = 1'b0; cpu_addr = 7'd13; step("R7");
    rx_msg(8'h88, 1'b0, "R7");
    scan_win("R7");
    release_one("R3");
    scan_win("R6");

    // hardware reset mid-run
    rx_msg(8'h03, 1'b0, "R1");
    rst_n = 1'b0; step("R1");
    cpu_addr = 7'd14; step("R1");
    rst_n = 1'b1; step("R1");
    cpu_addr = 7'd13; step("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule